// File: doc/BRIEF.md
# SIMD Execute Occupancy Stall Controller

This block drives the stall and PC-hold control for an in-order pipeline whose fetch and decode happen in one merged front stage. That stage sends each instruction either down a single-cycle scalar execute path or into a vector (SIMD) execute unit. The vector unit is not pipelined: it takes several cycles per instruction and accepts only one at a time. A position counter tracks how far the resident vector instruction has progressed. When a newly fetched vector instruction would collide with one that still has cycles to run, the block raises stall.

While stalled, the block selects a "hold" input on the PC multiplexer, so the next PC equals the current one. It also freezes the front pipeline register, so the waiting instruction is kept rather than discarded. Scalar instructions bypass the vector unit and never wait on it. The scalar next-PC select (sequential or ALU target) is passed through when there is no stall. It is widened by zero-extension, so it can never alias onto an unused multiplexer input. A strobe marks each cycle in which a vector instruction is accepted into the vector unit.

Top module: `simd_stall_top`

## Requirements
- R1: After reset, simdCount is 0, stall is 0 and frontInstr is 0.
- R2: simdIssue is 1 exactly when isSimd is 1 and stall is 0 in the same cycle.
- R3: After a cycle with simdIssue high, simdCount is 1. From 1 it counts up by one per cycle to 3 (the vector latency). After 3 it returns to 0, unless simdIssue was high in that cycle, in which case it reloads 1. It stays at 0 while nothing is issued.
- R4: stall is 1 when isSimd is 1 and simdCount is 1 or 2, using unsigned comparison.
- R5: A vector instruction fetched while simdCount is 0 or 3 does not stall.
- R6: stall is 0 whenever isSimd is 0, whatever the value of simdCount.
- R7: While stall is 1, pcSel is 2 (hold: next PC equals current PC).
- R8: While stall is 0, pcSel equals normPcSel zero-extended. The codes are 0 for PC+4 and 1 for the ALU target, and the value 3 never appears.
- R9: On a clock edge with stall low, frontInstr takes the value of instrIn. On an edge with stall high, frontInstr keeps its value, so no instruction is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isSimd | input | 1 | Front stage holds a vector instruction |
| normPcSel | input | 1 | Scalar next-PC select: 0 = PC+4, 1 = ALU target |
| instrIn | input | 32 | Instruction from the merged fetch/decode stage |
| stall | output | 1 | Front stage must wait |
| pcSel | output | 2 | Effective PC multiplexer select (2 = hold) |
| simdCount | output | 2 | Vector unit position, 0 = idle |
| simdIssue | output | 1 | A vector instruction enters the vector unit this cycle |
| frontInstr | output | 32 | Front pipeline register contents |

## Verification
The bench sweeps every 8-cycle pattern of the vector flag, while varying the scalar select and the instruction word, against an arithmetic occupancy model. Back-to-back vector instructions exercise the reload from 3 to 1 and the two stall cycles per collision. Gaps of one and two cycles separate the cases where the counter is at 2 (stall) from those where it is at 3 (no stall). Longer scalar runs show the return to 0 and show that scalar instructions pass while the unit is busy. Freezing the front register during stalls is checked by giving each cycle a distinct instruction word, so that a dropped or overwritten instruction shows at the output.

// File: rtl/simd_stall_pkg.sv
package simd_stall_pkg;
  typedef struct packed {
    logic stall;
    logic issue;
  } ctlStrobes_t;
endpackage

// File: rtl/simd_stall_ctl.sv
module simd_stall_ctl
  import simd_stall_pkg::*;
#(
  parameter int EX_CYCLES = 3,
  parameter int CNT_W     = $clog2(EX_CYCLES + 1)
) (
  input  logic             isSimd,
  input  logic [CNT_W-1:0] simdCount,
  output ctlStrobes_t      strobes
);
  localparam logic [CNT_W-1:0] LAST_BUSY = CNT_W'(EX_CYCLES - 1);

  logic unitBusyNext;

  // unit still occupied next cycle: counter within 1..EX_CYCLES-1 (unsigned)
  always_comb begin
    unitBusyNext  = (simdCount >= CNT_W'(1)) && (simdCount <= LAST_BUSY);
    strobes.stall = isSimd && unitBusyNext;
    strobes.issue = isSimd && !strobes.stall;
  end
endmodule

// File: rtl/simd_stall_dp.sv
module simd_stall_dp
  import simd_stall_pkg::*;
#(
  parameter int EX_CYCLES = 3,
  parameter int CNT_W     = $clog2(EX_CYCLES + 1),
  parameter int NSEL_W    = 1,
  parameter int PSEL_W    = NSEL_W + 1,
  parameter int INSTR_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [NSEL_W-1:0]  normPcSel,
  input  logic [INSTR_W-1:0] instrIn,
  output logic [CNT_W-1:0]   simdCount,
  output logic [PSEL_W-1:0]  pcSel,
  output logic [INSTR_W-1:0] frontInstr
);
  localparam logic [CNT_W-1:0]  LAST_POS  = CNT_W'(EX_CYCLES);
  localparam logic [PSEL_W-1:0] HOLD_CODE = PSEL_W'(2 ** NSEL_W);

  logic [CNT_W-1:0] countNext;

  always_comb begin
    if (strobes.issue)
      countNext = CNT_W'(1);
    else if (simdCount == '0 || simdCount == LAST_POS)
      countNext = '0;
    else
      countNext = simdCount + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) simdCount <= '0;
    else       simdCount <= countNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              frontInstr <= '0;
    else if (!strobes.stall) frontInstr <= instrIn;
  end

  // zero-extend the scalar select so it never reaches an unused input
  always_comb begin
    if (strobes.stall) pcSel = HOLD_CODE;
    else               pcSel = {{(PSEL_W - NSEL_W){1'b0}}, normPcSel};
  end
endmodule

// File: rtl/simd_stall_top.sv
module simd_stall_top
  import simd_stall_pkg::*;
#(
  parameter int EX_CYCLES = 3,
  parameter int CNT_W     = $clog2(EX_CYCLES + 1),
  parameter int NSEL_W    = 1,
  parameter int PSEL_W    = NSEL_W + 1,
  parameter int INSTR_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               isSimd,
  input  logic [NSEL_W-1:0]  normPcSel,
  input  logic [INSTR_W-1:0] instrIn,
  output logic               stall,
  output logic [PSEL_W-1:0]  pcSel,
  output logic [CNT_W-1:0]   simdCount,
  output logic               simdIssue,
  output logic [INSTR_W-1:0] frontInstr
);
  ctlStrobes_t strobes;

  simd_stall_ctl #(.EX_CYCLES(EX_CYCLES), .CNT_W(CNT_W)) i_ctl (
    .isSimd    (isSimd),
    .simdCount (simdCount),
    .strobes   (strobes)
  );

  simd_stall_dp #(
    .EX_CYCLES(EX_CYCLES), .CNT_W(CNT_W), .NSEL_W(NSEL_W),
    .PSEL_W(PSEL_W), .INSTR_W(INSTR_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .normPcSel  (normPcSel),
    .instrIn    (instrIn),
    .simdCount  (simdCount),
    .pcSel      (pcSel),
    .frontInstr (frontInstr)
  );

  assign stall     = strobes.stall;
  assign simdIssue = strobes.issue;
endmodule

// File: rtl/simd_stall_chk.sv
module simd_stall_chk #(
  parameter int EX_CYCLES = 3,
  parameter int CNT_W     = $clog2(EX_CYCLES + 1),
  parameter int NSEL_W    = 1,
  parameter int PSEL_W    = NSEL_W + 1,
  parameter int INSTR_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               isSimd,
  input logic [NSEL_W-1:0]  normPcSel,
  input logic               stall,
  input logic [PSEL_W-1:0]  pcSel,
  input logic [CNT_W-1:0]   simdCount,
  input logic               simdIssue,
  input logic [INSTR_W-1:0] frontInstr
);
  localparam logic [CNT_W-1:0]  LAST_POS  = CNT_W'(EX_CYCLES);
  localparam logic [PSEL_W-1:0] HOLD_CODE = PSEL_W'(2 ** NSEL_W);

  AST_ISSUE_LOADS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    simdIssue |=> simdCount == CNT_W'(1));                              // R3
  AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (simdCount != '0 && simdCount != LAST_POS && !simdIssue)
      |=> simdCount == $past(simdCount) + CNT_W'(1));                   // R3
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    simdCount <= LAST_POS);                                             // R3
  AST_NO_SCALAR_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !isSimd |-> !stall);                                                // R6
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (simdCount == '0 || simdCount == LAST_POS) |-> !stall);             // R5
  AST_ISSUE_EXCL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !(simdIssue && stall));                                             // R2
  AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> pcSel == HOLD_CODE);                                      // R7
  AST_NO_BAD_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !stall |-> pcSel < HOLD_CODE);                                      // R8
  AST_FRONT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(frontInstr));                                     // R9
endmodule

bind simd_stall_top simd_stall_chk #(
  .EX_CYCLES(EX_CYCLES), .CNT_W(CNT_W), .NSEL_W(NSEL_W),
  .PSEL_W(PSEL_W), .INSTR_W(INSTR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .isSimd(isSimd), .normPcSel(normPcSel),
  .stall(stall), .pcSel(pcSel), .simdCount(simdCount),
  .simdIssue(simdIssue), .frontInstr(frontInstr)
);

// File: tb/test_simd_stall_top.sv
module test_simd_stall_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isSimd = 1'b0;
  logic [0:0]  normPcSel = 1'b0;
  logic [31:0] instrIn = '0;
  logic        stall;
  logic [1:0]  pcSel;
  logic [1:0]  simdCount;
  logic        simdIssue;
  logic [31:0] frontInstr;

  int total = 0;
  int bad = 0;
  int expCnt = 0;
  logic [31:0] expFront = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  simd_stall_top i_simd_stall_top (
    .clk(clk), .rstN(rstN), .isSimd(isSimd), .normPcSel(normPcSel),
    .instrIn(instrIn), .stall(stall), .pcSel(pcSel), .simdCount(simdCount),
    .simdIssue(simdIssue), .frontInstr(frontInstr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic simd, input logic sel, input logic [31:0] ins);
    logic eStall;
    logic eIssue;
    @(negedge clk);
    isSimd = simd; normPcSel = sel; instrIn = ins;
    #2;
    eStall = simd && (expCnt == 1 || expCnt == 2);
    eIssue = simd && !eStall;
    chk("R3 count", 32'(simdCount), 32'(expCnt));
    chk(simd ? "R4/R5 stall" : "R6 stall", 32'(stall), 32'(eStall));
    chk("R2 issue", 32'(simdIssue), 32'(eIssue));
    chk(eStall ? "R7 pcSel" : "R8 pcSel", 32'(pcSel), eStall ? 32'd2 : 32'(sel));
    chk("R9 front", frontInstr, expFront);
    @(posedge clk);
    if (eIssue) expCnt = 1;
    else if (expCnt == 0 || expCnt == 3) expCnt = 0;
    else expCnt = expCnt + 1;
    if (!eStall) expFront = ins;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 count", 32'(simdCount), 32'd0);
    chk("R1 stall", 32'(stall), 32'd0);
    chk("R1 front", frontInstr, 32'd0);
    rstN = 1'b1;
    // fixed scenario: back-to-back vector, then gap of 2, then scalars
    step(1'b1, 1'b0, 32'h100);
    step(1'b1, 1'b1, 32'h101);
    step(1'b1, 1'b0, 32'h102);
    step(1'b1, 1'b1, 32'h103);
    step(1'b0, 1'b1, 32'h104);
    step(1'b0, 1'b0, 32'h105);
    step(1'b1, 1'b0, 32'h106);
    for (int k = 0; k < 5; k++) step(1'b0, k[0], 32'h200 + 32'(k));
    // exhaustive sweep of 8-cycle vector-flag patterns
    for (int pat = 0; pat < 256; pat++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] p;
        p = 8'(pat);
        step(p[k], p[(k + 3) % 8] ^ k[0], 32'(pat) * 32'd16 + 32'(k));
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule